// File: doc/BRIEF.md
# Message-Signalled Interrupt Address Generator

This block turns an interrupt delivery decision into one memory write request. A source is offered as a 32-bit target word that names a hart, a guest and an interrupt identity. The block combines that word with two 32-bit placement registers and produces a 64-bit byte address together with a 32-bit data word carrying the identity. The placement registers hold the upper base page bits and five placement controls.

The page number is built from several parts. The hart index is split into a group part and a per-group hart part, and each part is placed at its own shift. The guest index fills the lowest page bits, and the base page number is ORed in. The byte address is that page number followed by twelve zero bits. In a machine-level domain the guest index is treated as zero.

Both placement registers can be written. A lock bit in the upper register freezes both of them until reset. The result is held in a one-entry output stage with a valid/ready handshake. A new source is taken only while delivery is enabled and no request is waiting.

Top module: `msi_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, both placement registers read zero and `msg_valid` is low.
- R2: A write to the upper register keeps only bits 31, 28:24, 22:20, 18:16 and 15:0 (keep mask 0x9F77FFFF). All other bits read zero. A write to the lower register keeps all 32 bits. A written value is visible on the read outputs the cycle after the write.
- R3: While bit 31 of the upper register is 1, writes to both registers have no effect. Messages keep using the locked values.
- R4: The target word is decoded as hart index in bits 31:18, guest index in bits 17:12 and identity in bits 10:0. Bit 11 is ignored.
- R5: Upper register fields: group shift S_g in 28:24, hart shift S_h in 22:20, group width W_g in 18:16, hart width W_h in 15:12, base page bits 43:32 in 11:0. The lower register holds base page bits 31:0. The page number is the base, ORed with ((hart >> W_h) masked to W_g bits) << (S_g+12), ORed with (hart masked to W_h bits) << S_h, ORed with guest masked to S_h bits. `msg_addr` is the page number shifted left by 12.
- R6: When `machine_dom` is 1, the guest index is taken as zero.
- R7: `msg_data` is the 11-bit identity, zero-extended to 32 bits.
- R8: `src_ready` is high only when `deliver_en` is 1 and no request is outstanding. Each accepted source produces exactly one request.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. Register writes made after acceptance do not change the waiting request.
- R10: `msg_valid` rises in the cycle after a source is accepted. It falls in the cycle after `msg_valid` and `msg_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lo_we | input | 1 | Lower placement register write enable |
| cfg_lo_wdata | input | 32 | Lower placement register write data |
| cfg_hi_we | input | 1 | Upper placement register write enable |
| cfg_hi_wdata | input | 32 | Upper placement register write data |
| cfg_lo_q | output | 32 | Lower placement register value |
| cfg_hi_q | output | 32 | Upper placement register value |
| machine_dom | input | 1 | Domain is machine level; guest index is forced to zero |
| deliver_en | input | 1 | Delivery enable; no source is taken while low |
| src_valid | input | 1 | A source target word is offered |
| src_target | input | 32 | Target word of the offered source |
| src_ready | output | 1 | The offered source is taken this cycle |
| msg_valid | output | 1 | Write request valid |
| msg_addr | output | 64 | Write request byte address |
| msg_data | output | 32 | Write request data word |
| msg_ready | input | 1 | Write request accepted by the downstream side |

## Verification
A wrong placement register value shows up in the register outputs one cycle after the write. It also shows up in the address of the next request, because each request is compared against an address computed independently from the bench's own register copy. A broken lock or keep mask appears at the first write after the lock is set or at the first masked write. A fault in the output stage shows within a cycle of the handshake: a lost, duplicated or changed request, or a valid that fails to rise or fall. Under back-pressure, a request that changes while waiting is caught on the next sampled cycle.

// File: rtl/msi_pkg.sv
// Shared geometry of the placement registers and the target word.
// Assumes a 32-bit register width; field positions are fixed because
// software and the source table both depend on them.
package msi_pkg;

    localparam int unsigned REG_W       = 32;
    localparam int unsigned PAGE_SHIFT  = 12;

    // upper placement register field positions
    localparam int unsigned LOCK_POS    = 31;
    localparam int unsigned GSHIFT_LSB  = 24;
    localparam int unsigned GSHIFT_W    = 5;
    localparam int unsigned HSHIFT_LSB  = 20;
    localparam int unsigned HSHIFT_W    = 3;
    localparam int unsigned GWIDTH_LSB  = 16;
    localparam int unsigned GWIDTH_W    = 3;
    localparam int unsigned HWIDTH_LSB  = 12;
    localparam int unsigned HWIDTH_W    = 4;
    localparam int unsigned BASEHI_W    = 12;

    localparam logic [REG_W-1:0] HI_KEEP_MASK =
        (REG_W'(1) << LOCK_POS) |
        (((REG_W'(1) << GSHIFT_W) - 1) << GSHIFT_LSB) |
        (((REG_W'(1) << HSHIFT_W) - 1) << HSHIFT_LSB) |
        (((REG_W'(1) << GWIDTH_W) - 1) << GWIDTH_LSB) |
        (((REG_W'(1) << HWIDTH_W) - 1) << HWIDTH_LSB) |
        ((REG_W'(1) << BASEHI_W) - 1);

    // target word field positions
    localparam int unsigned HART_W      = 14;
    localparam int unsigned HART_LSB    = 18;
    localparam int unsigned GUEST_W     = 6;
    localparam int unsigned GUEST_LSB   = 12;
    localparam int unsigned IDENT_W     = 11;

    typedef struct packed {
        logic                 lock;
        logic [GSHIFT_W-1:0]  grp_shift;
        logic [HSHIFT_W-1:0]  hart_shift;
        logic [GWIDTH_W-1:0]  grp_width;
        logic [HWIDTH_W-1:0]  hart_width;
        logic [BASEHI_W-1:0]  base_hi;
    } place_cfg_t;

    typedef struct packed {
        logic [HART_W-1:0]    hart;
        logic [GUEST_W-1:0]   guest;
        logic [IDENT_W-1:0]   ident;
    } dest_t;

    function automatic place_cfg_t unpack_hi(input logic [REG_W-1:0] w);
        place_cfg_t c;
        c.lock       = w[LOCK_POS];
        c.grp_shift  = w[GSHIFT_LSB +: GSHIFT_W];
        c.hart_shift = w[HSHIFT_LSB +: HSHIFT_W];
        c.grp_width  = w[GWIDTH_LSB +: GWIDTH_W];
        c.hart_width = w[HWIDTH_LSB +: HWIDTH_W];
        c.base_hi    = w[BASEHI_W-1:0];
        return c;
    endfunction

    function automatic dest_t unpack_target(input logic [REG_W-1:0] w);
        dest_t d;
        d.hart  = w[HART_LSB +: HART_W];
        d.guest = w[GUEST_LSB +: GUEST_W];
        d.ident = w[IDENT_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/msi_place_regs.sv
// Placement register pair with a keep mask on the upper word and a
// sticky lock. Assumes writes are single-cycle strobes; the lock is
// evaluated on the value held before the write, so the write that sets
// the lock is itself accepted.
module msi_place_regs
    import msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we,
    input  logic [REG_W-1:0] lo_wdata,
    input  logic             hi_we,
    input  logic [REG_W-1:0] hi_wdata,
    output logic [REG_W-1:0] lo_q,
    output logic [REG_W-1:0] hi_q
);

    logic locked;
    assign locked = hi_q[LOCK_POS];

    // register update: full lower word, masked upper word, both frozen when locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (!locked) begin
            if (lo_we) lo_q <= lo_wdata;
            if (hi_we) hi_q <= hi_wdata & HI_KEEP_MASK;
        end
    end

    // R3: once locked, neither register moves
    a_r3_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(lo_q) && $stable(hi_q)));

    // R2: an unlocked upper write lands with the reserved bits cleared
    a_r2_hi_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !locked) |=> (hi_q == ($past(hi_wdata) & HI_KEEP_MASK)));

    // R2: an unlocked lower write lands whole
    a_r2_lo_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !locked) |=> (lo_q == $past(lo_wdata)));

endmodule

// File: rtl/msi_place_calc.sv
// Combinational page-number builder. Splits the hart index into a
// group part and a per-group hart part, places each at its own shift,
// ORs in the guest index and the base, then forms the byte address.
// Assumes the caller has already zeroed the guest for machine domains.
module msi_place_calc
    import msi_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 32
) (
    input  logic [REG_W-1:0]   lo_cfg,
    input  logic [REG_W-1:0]   hi_cfg,
    input  logic [HART_W-1:0]  hart,
    input  logic [GUEST_W-1:0] guest,
    input  logic [IDENT_W-1:0] ident,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  data
);

    localparam int unsigned PPN_W   = ADDR_W - PAGE_SHIFT;
    localparam int unsigned SHAMT_W = GSHIFT_W + 1;

    typedef logic [PPN_W-1:0] ppn_t;

    place_cfg_t          cfg;
    ppn_t                base_ppn;
    ppn_t                hart_wide;
    ppn_t                grp_mask;
    ppn_t                hart_mask;
    ppn_t                guest_mask;
    ppn_t                grp_part;
    ppn_t                hart_part;
    ppn_t                guest_part;
    ppn_t                ppn;
    logic [SHAMT_W-1:0]  grp_shamt;

    assign cfg = unpack_hi(hi_cfg);

    // base page number from the two registers
    always_comb begin
        base_ppn = ppn_t'({cfg.base_hi, lo_cfg});
    end

    // field masks derived from the configured widths
    always_comb begin
        hart_wide  = ppn_t'(hart);
        grp_mask   = (ppn_t'(1) << cfg.grp_width)  - ppn_t'(1);
        hart_mask  = (ppn_t'(1) << cfg.hart_width) - ppn_t'(1);
        guest_mask = (ppn_t'(1) << cfg.hart_shift) - ppn_t'(1);
        grp_shamt  = SHAMT_W'(cfg.grp_shift) + SHAMT_W'(PAGE_SHIFT);
    end

    // place group, hart and guest parts
    always_comb begin
        grp_part   = ((hart_wide >> cfg.hart_width) & grp_mask) << grp_shamt;
        hart_part  = (hart_wide & hart_mask) << cfg.hart_shift;
        guest_part = ppn_t'(guest) & guest_mask;
        ppn        = base_ppn | grp_part | hart_part | guest_part;
    end

    // byte address and data word
    always_comb begin
        addr = {ppn, {PAGE_SHIFT{1'b0}}};
        data = DATA_W'(ident);
    end

endmodule

// File: rtl/msi_msg_hold.sv
// One-entry output stage for the write request. Assumes the loader
// never loads while a request is outstanding; contents hold until the
// downstream side takes them.
module msi_msg_hold #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    // capture on load, release on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            data_o  <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            addr_o  <= addr_i;
            data_o  <= data_i;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

    // R9: a waiting request does not change
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));

    // R10: valid rises after a load
    a_r10_load_raises: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> valid_o);

    // R10: valid falls after a handshake
    a_r10_take_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !load_i) |=> !valid_o);

    // R8: never load over an outstanding request
    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !valid_o);

endmodule

// File: rtl/msi_addr_gen.sv
// Top level: decodes the target word, forces the guest to zero in a
// machine domain, builds the address from the placement registers and
// holds the resulting write request until it is taken. Assumes
// deliver_en and machine_dom are quasi-static domain settings.
module msi_addr_gen
    import msi_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_lo_we,
    input  logic [31:0]       cfg_lo_wdata,
    input  logic              cfg_hi_we,
    input  logic [31:0]       cfg_hi_wdata,
    output logic [31:0]       cfg_lo_q,
    output logic [31:0]       cfg_hi_q,
    input  logic              machine_dom,
    input  logic              deliver_en,
    input  logic              src_valid,
    input  logic [31:0]       src_target,
    output logic              src_ready,
    output logic              msg_valid,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data,
    input  logic              msg_ready
);

    dest_t               dest;
    logic [GUEST_W-1:0]  guest_eff;
    logic [ADDR_W-1:0]   next_addr;
    logic [DATA_W-1:0]   next_data;
    logic                take;

    msi_place_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_we    (cfg_lo_we),
        .lo_wdata (cfg_lo_wdata),
        .hi_we    (cfg_hi_we),
        .hi_wdata (cfg_hi_wdata),
        .lo_q     (cfg_lo_q),
        .hi_q     (cfg_hi_q)
    );

    // target decode and machine-domain guest suppression
    always_comb begin
        dest      = unpack_target(src_target);
        guest_eff = machine_dom ? '0 : dest.guest;
    end

    msi_place_calc #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_calc (
        .lo_cfg (cfg_lo_q),
        .hi_cfg (cfg_hi_q),
        .hart   (dest.hart),
        .guest  (guest_eff),
        .ident  (dest.ident),
        .addr   (next_addr),
        .data   (next_data)
    );

    // accept a source only when enabled and nothing is waiting
    always_comb begin
        src_ready = deliver_en && !msg_valid;
        take      = src_valid && src_ready;
    end

    msi_msg_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (take),
        .addr_i  (next_addr),
        .data_i  (next_data),
        .valid_o (msg_valid),
        .ready_i (msg_ready),
        .addr_o  (msg_addr),
        .data_o  (msg_data)
    );

    // R5: every request address is page aligned
    a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[PAGE_SHIFT-1:0] == '0));

    // R7: data carries only the identity bits
    a_r7_data_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_data >> IDENT_W) == '0));

endmodule

// File: tb/msi_addr_gen_test.sv
module msi_addr_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEEP = 32'h9F77_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_lo_we, cfg_hi_we;
    logic [31:0] cfg_lo_wdata, cfg_hi_wdata, cfg_lo_q, cfg_hi_q;
    logic        machine_dom, deliver_en, src_valid, src_ready;
    logic [31:0] src_target;
    logic        msg_valid, msg_ready;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int cyc = 0;
    logic [31:0] m_lo = '0, m_hi = '0;

    logic [63:0] exp_addr_q[$];
    logic [31:0] exp_data_q[$];
    string       exp_tag_q[$];

    msi_addr_gen uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_lo_we(cfg_lo_we), .cfg_lo_wdata(cfg_lo_wdata),
        .cfg_hi_we(cfg_hi_we), .cfg_hi_wdata(cfg_hi_wdata),
        .cfg_lo_q(cfg_lo_q), .cfg_hi_q(cfg_hi_q),
        .machine_dom(machine_dom), .deliver_en(deliver_en),
        .src_valid(src_valid), .src_target(src_target), .src_ready(src_ready),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
        .msg_ready(msg_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected address from the R5 formula, with R4 decode and R6 guest rule
    function automatic logic [63:0] model_addr(input logic [31:0] lo, input logic [31:0] hi,
                                               input logic [31:0] tgt, input logic md);
        longint unsigned hart, guest, grp, ppn;
        int gs, hs, gw, hw;
        hart  = 64'(tgt[31:18]);
        guest = md ? 64'd0 : 64'(tgt[17:12]);
        gs = int'(hi[28:24]); hs = int'(hi[22:20]);
        gw = int'(hi[18:16]); hw = int'(hi[15:12]);
        ppn = {20'd0, hi[11:0], lo};
        grp = hart >> hw;
        ppn = ppn | ((grp & ((64'd1 << gw) - 1)) << (gs + 12));
        ppn = ppn | ((hart & ((64'd1 << hw) - 1)) << hs);
        ppn = ppn | (guest & ((64'd1 << hs) - 1));
        return ppn << 12;
    endfunction

    function automatic logic [31:0] mk_tgt(input int hart, input int guest, input int id);
        return {14'(hart), 6'(guest), 1'b0, 11'(id)};
    endfunction

    // ready pattern generator
    always @(posedge clk) begin
        #1;
        cyc++;
        case (rdy_mode)
            0: msg_ready = 1'b1;
            1: msg_ready = ((cyc % 3) == 0);
            default: msg_ready = 1'b0;
        endcase
    end

    // monitor: pop and compare, check hold (R9) and drop timing (R10)
    bit          drop_due = 0;
    bit          held = 0;
    logic [63:0] prev_addr;
    logic [31:0] prev_data;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (drop_due) begin
                check(msg_valid == 1'b0, "R10 drop", 64'(msg_valid), 64'd0);
                drop_due = 0;
            end
            if (held && msg_valid) begin
                check(msg_addr == prev_addr && msg_data == prev_data, "R9 hold",
                      msg_addr, prev_addr);
            end else if (held) begin
                check(1'b0, "R9 valid held", 64'(msg_valid), 64'd1);
            end
            if (msg_valid && msg_ready) begin
                if (exp_addr_q.size() == 0) begin
                    check(1'b0, "R8 unexpected request", msg_addr, 64'd0);
                end else begin
                    string t;
                    t = exp_tag_q.pop_front();
                    check(msg_addr == exp_addr_q[0], {t, " addr"}, msg_addr, exp_addr_q[0]);
                    check(msg_data == exp_data_q[0], "R7 data", 64'(msg_data), 64'(exp_data_q[0]));
                    void'(exp_addr_q.pop_front());
                    void'(exp_data_q.pop_front());
                end
                drop_due = 1;
                held = 0;
            end else if (msg_valid) begin
                held = 1;
                prev_addr = msg_addr;
                prev_data = msg_data;
            end else begin
                held = 0;
            end
        end
    end

    // driver: write a placement register and check readback
    task automatic cfg_write(input bit upper, input logic [31:0] val, input string tag);
        @(posedge clk); #1;
        if (upper) begin cfg_hi_we = 1; cfg_hi_wdata = val; end
        else       begin cfg_lo_we = 1; cfg_lo_wdata = val; end
        if (!m_hi[31]) begin
            if (upper) m_hi = val & KEEP;
            else       m_lo = val;
        end
        @(posedge clk); #1;
        cfg_hi_we = 0; cfg_lo_we = 0;
        @(negedge clk);
        check(cfg_lo_q == m_lo, {tag, " lo"}, 64'(cfg_lo_q), 64'(m_lo));
        check(cfg_hi_q == m_hi, {tag, " hi"}, 64'(cfg_hi_q), 64'(m_hi));
    endtask

    // driver: offer a source, push the expected request at acceptance
    task automatic send(input logic [31:0] tgt, input string tag);
        @(posedge clk); #1;
        src_valid = 1; src_target = tgt;
        do @(negedge clk); while (!src_ready);
        exp_addr_q.push_back(model_addr(m_lo, m_hi, tgt, machine_dom));
        exp_data_q.push_back({21'd0, tgt[10:0]});
        exp_tag_q.push_back(tag);
        @(posedge clk); #1;
        src_valid = 0;
        @(negedge clk);
        check(msg_valid == 1'b1, "R10 rise", 64'(msg_valid), 64'd1);
    endtask

    task automatic drain();
        while (exp_addr_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_lo_we = 0; cfg_hi_we = 0; cfg_lo_wdata = 0; cfg_hi_wdata = 0;
        machine_dom = 0; deliver_en = 1; src_valid = 0; src_target = 0; msg_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cfg_lo_q == 0, "R1 lo", 64'(cfg_lo_q), 0);
        check(cfg_hi_q == 0, "R1 hi", 64'(cfg_hi_q), 0);
        check(msg_valid == 0, "R1 valid", 64'(msg_valid), 0);
        @(posedge clk); #1; rst_n = 1;

        // R2: reserved bits 30,29,23,19 must be dropped
        cfg_write(1, 32'h6088_0000 | (5 << 24) | (2 << 20) | (3 << 16) | (4 << 12) | 32'h0AB, "R2");
        cfg_write(0, 32'h1200_0000, "R2");

        // R5/R4 with several harts, guests and identities
        send(mk_tgt(14'h0000, 0, 1), "R5");
        send(mk_tgt(14'h3FFF, 6'h3F, 11'h7FF), "R5");
        send(mk_tgt(14'h00A5, 6'h02, 11'h123), "R5");
        send(mk_tgt(14'h1234, 6'h15, 11'h400) | 32'h800, "R4");
        machine_dom = 1;
        send(mk_tgt(14'h0037, 6'h3F, 11'h055), "R6");
        machine_dom = 0;
        drain();

        // second placement, hart width zero, under back-pressure
        cfg_write(1, (0 << 24) | (6 << 20) | (7 << 16) | (0 << 12) | 32'h001, "R2");
        rdy_mode = 1;
        send(mk_tgt(14'h2AAA, 6'h2C, 11'h0F0), "R5");
        send(mk_tgt(14'h007F, 6'h3F, 11'h001), "R5");
        drain();

        // R9/R8: request waits, later register write must not change it
        rdy_mode = 2;
        send(mk_tgt(14'h0155, 6'h11, 11'h321), "R9");
        src_valid = 1; src_target = mk_tgt(1, 1, 1);
        @(negedge clk);
        check(src_ready == 0, "R8 outstanding", 64'(src_ready), 0);
        src_valid = 0;
        cfg_write(0, 32'hDEAD_B000, "R9");
        repeat (3) @(negedge clk);
        rdy_mode = 0;
        drain();

        // R8: delivery disabled, nothing taken
        deliver_en = 0;
        @(posedge clk); #1; src_valid = 1; src_target = mk_tgt(3, 3, 3);
        repeat (4) begin
            @(negedge clk);
            check(src_ready == 0, "R8 disabled ready", 64'(src_ready), 0);
            check(msg_valid == 0, "R8 disabled valid", 64'(msg_valid), 0);
        end
        @(posedge clk); #1; src_valid = 0; deliver_en = 1;

        // R3: lock freezes both registers
        cfg_write(1, 32'h8000_0000 | (31 << 24) | (0 << 20) | (2 << 16) | (15 << 12) | 32'hFFF, "R3");
        cfg_write(0, 32'h0000_0001, "R3");
        cfg_write(1, 32'h0000_0000, "R3");
        send(mk_tgt(14'h3ABC, 6'h05, 11'h2A2), "R3");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule